// File: doc/BRIEF.md
# Programmable SRAM Bus Cycle Controller

This block turns single requests from an on-chip master into bus cycles on an external asynchronous SRAM-style bus. The master presents an address, write data, byte enables and a direction under a valid/ready handshake. The block checks whether the address belongs to the one memory area it serves. For an address in its area it runs a full bus cycle: chip select is asserted, then a read strobe (also used as output enable) or per-byte write strobes, then chip select is released.

Each bus cycle has three phases, and configuration inputs control all of them. The setup phase is zero or one cycle. The strobe phase lasts for a programmed number of wait cycles, chosen from a table of eight counts, and an external ready pin can then stretch it without limit. The hold phase is zero to three cycles. A size field sets the data bus width to 8, 16, 32 or 64 bits, and write strobes above that width stay idle. The configuration is copied when a request is accepted, so the master can rewrite it while a cycle is running without disturbing that cycle.

Top module: `sram_cycle_ctrl`

## Requirements
- R1: Out of reset, `bus_cs_n`, `bus_rd_n` and all of `bus_we_n` are high, `req_ready` is high and `rsp_done` is low.
- R2: An accepted request whose address bits [28:26] equal `AREA_CODE` (default 3'b010) runs a bus cycle, and `bus_cs_n` goes low in the cycle after acceptance. Any other address never lowers `bus_cs_n` or a strobe. It completes with `rsp_done` in the cycle after acceptance, and `rsp_rdata` is zero.
- R3: When `cfg_setup` is 1, `bus_cs_n` is low for one cycle before the strobe starts. When it is 0, the strobe starts in the same cycle as chip select.
- R4: With `ext_ready` high, the strobe is active for W+1 cycles. W is the wait count that `cfg_wait` selects: codes 0..7 give 0, 1, 2, 3, 4, 6, 8 and 15.
- R5: `ext_ready` is ignored during the first W strobe cycles. From then on, each cycle in which it is low adds one strobe cycle, and the strobe ends in the first such cycle in which it is high.
- R6: After the strobe is released, `bus_cs_n` stays low for `cfg_hold` (0 to 3) further cycles.
- R7: A read drives `bus_rd_n` low during the strobe with all `bus_we_n` high. `bus_rdata` is captured in the last strobe cycle and appears on `rsp_rdata` when `rsp_done` pulses, in the cycle in which `bus_cs_n` returns high.
- R8: A write keeps `bus_rd_n` high and drives `bus_we_n[i]` low during the strobe exactly when `req_be[i]` is set and lane i lies within the configured width. `cfg_width` 0/1/2/3 selects 1/2/4/8 lanes (8/16/32/64 bits). `bus_wdata` carries `req_wdata`.
- R9: `req_ready` is high only while no bus cycle is in progress, so a new request is taken only after the hold phase has finished.
- R10: Configuration inputs are sampled when the request is accepted. Changing them during the cycle has no effect on that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Request address |
| req_wdata | input | 8*LANES | Write data |
| req_be | input | LANES | Byte enables |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 8*LANES | Read data |
| cfg_width | input | 2 | Bus width code |
| cfg_wait | input | 3 | Wait code |
| cfg_setup | input | 1 | Setup cycles (0 or 1) |
| cfg_hold | input | 2 | Hold cycles (0 to 3) |
| bus_cs_n | output | 1 | Chip select, active low |
| bus_rd_n | output | 1 | Read strobe / output enable, active low |
| bus_we_n | output | LANES | Per-byte write strobes, active low |
| bus_addr | output | ADDR_W | Bus address |
| bus_wdata | output | 8*LANES | Bus write data |
| bus_wdata_oe | output | 1 | Write data drive enable |
| bus_rdata | input | 8*LANES | Bus read data |
| ext_ready | input | 1 | External ready, high = ready |

## Verification
The hardest case to reach from the ports is a not-ready level on the ready pin that has to land at a particular strobe cycle. It must fall either inside the programmed wait window, where it has to be ignored, or just after it, where each low cycle must add exactly one strobe cycle. The bench's bus model counts strobe cycles as they happen and derives the ready level from the access at the head of the expectation queue, so it can place the not-ready cycles either before or after the wait window. A second case is a configuration rewrite made between acceptance and completion. The driver does this right after the handshake, and the expected item still describes the original settings.

// File: rtl/sram_cyc_pkg.sv
package sram_cyc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETUP  = 2'd1,
    ST_STROBE = 2'd2,
    ST_HOLD   = 2'd3
  } seq_state_t;

  // Wait code to wait-cycle count
  function automatic logic [3:0] wait_count(input logic [2:0] code);
    logic [3:0] n;
    case (code)
      3'd0:    n = 4'd0;
      3'd1:    n = 4'd1;
      3'd2:    n = 4'd2;
      3'd3:    n = 4'd3;
      3'd4:    n = 4'd4;
      3'd5:    n = 4'd6;
      3'd6:    n = 4'd8;
      default: n = 4'd15;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/sram_area_decode.sv
module sram_area_decode #(
  parameter int          AREA_W    = 3,
  parameter logic [2:0]  AREA_CODE = 3'b010
) (
  input  logic [AREA_W-1:0] area_bits_i,
  output logic              hit_o
);

  assign hit_o = (area_bits_i == AREA_CODE[AREA_W-1:0]);

endmodule

// File: rtl/sram_lane_mask.sv
module sram_lane_mask #(
  parameter int LANES = 8,
  localparam int WSZ_W = $clog2($clog2(LANES) + 1)
) (
  input  logic [WSZ_W-1:0] width_i,
  input  logic [LANES-1:0] be_i,
  output logic [LANES-1:0] be_o
);

  logic [31:0] lane_cnt;
  assign lane_cnt = 32'd1 << width_i;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign be_o[i] = be_i[i] && (32'(i) < lane_cnt);
  end

endmodule

// File: rtl/sram_cycle_fsm.sv
module sram_cycle_fsm
  import sram_cyc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       setup_i,
  input  logic [2:0] wcode_i,
  input  logic [1:0] hold_i,
  input  logic       ext_ready_i,
  output logic       idle_o,
  output logic       cs_o,
  output logic       strobe_o,
  output logic       capture_o,
  output logic       finish_o
);

  seq_state_t state_q, state_d;
  logic [3:0] wcnt_q, wcnt_d;
  logic [1:0] hcnt_q, hcnt_d;
  logic       seq_en;

  always_comb begin
    state_d   = state_q;
    wcnt_d    = wcnt_q;
    hcnt_d    = hcnt_q;
    capture_o = 1'b0;
    finish_o  = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          state_d = setup_i ? ST_SETUP : ST_STROBE;
          wcnt_d  = wait_count(wcode_i);
          hcnt_d  = hold_i;
        end
      end
      ST_SETUP: state_d = ST_STROBE;
      ST_STROBE: begin
        if (wcnt_q != 4'd0) begin
          wcnt_d = wcnt_q - 4'd1;
        end else if (ext_ready_i) begin
          capture_o = 1'b1;
          if (hcnt_q != 2'd0) begin
            state_d = ST_HOLD;
          end else begin
            state_d  = ST_IDLE;
            finish_o = 1'b1;
          end
        end
      end
      ST_HOLD: begin
        if (hcnt_q == 2'd1) begin
          state_d  = ST_IDLE;
          finish_o = 1'b1;
        end else begin
          hcnt_d = hcnt_q - 2'd1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign seq_en = (state_q != ST_IDLE) || start_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      wcnt_q  <= 4'd0;
      hcnt_q  <= 2'd0;
    end else if (seq_en) begin
      state_q <= state_d;
      wcnt_q  <= wcnt_d;
      hcnt_q  <= hcnt_d;
    end
  end

  assign idle_o   = (state_q == ST_IDLE);
  assign cs_o     = (state_q != ST_IDLE);
  assign strobe_o = (state_q == ST_STROBE);

  // R5
  strobe_end_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(strobe_o) |-> $past(ext_ready_i));

  // R9
  finish_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    finish_o |=> idle_o);

endmodule

// File: rtl/sram_cycle_ctrl.sv
module sram_cycle_ctrl
  import sram_cyc_pkg::*;
#(
  parameter int         ADDR_W    = 32,
  parameter int         LANES     = 8,
  parameter int         AREA_LSB  = 26,
  parameter logic [2:0] AREA_CODE = 3'b010,
  localparam int        DATA_W    = 8 * LANES,
  localparam int        WSZ_W     = $clog2($clog2(LANES) + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [LANES-1:0]  req_be,
  output logic              rsp_done,
  output logic [DATA_W-1:0] rsp_rdata,
  input  logic [WSZ_W-1:0]  cfg_width,
  input  logic [2:0]        cfg_wait,
  input  logic              cfg_setup,
  input  logic [1:0]        cfg_hold,
  output logic              bus_cs_n,
  output logic              bus_rd_n,
  output logic [LANES-1:0]  bus_we_n,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  output logic              bus_wdata_oe,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              ext_ready
);

  logic              area_hit, accept, start, miss;
  logic              fsm_idle, fsm_cs, fsm_strobe, fsm_capture, fsm_finish;
  logic [LANES-1:0]  be_masked;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q, rdata_d;
  logic [LANES-1:0]  be_q;
  logic              write_q, done_q, rdata_en;

  sram_area_decode #(
    .AREA_W    (3),
    .AREA_CODE (AREA_CODE)
  ) u_decode (
    .area_bits_i (req_addr[AREA_LSB +: 3]),
    .hit_o       (area_hit)
  );

  sram_lane_mask #(.LANES(LANES)) u_lanes (
    .width_i (cfg_width),
    .be_i    (req_be),
    .be_o    (be_masked)
  );

  sram_cycle_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start),
    .setup_i     (cfg_setup),
    .wcode_i     (cfg_wait),
    .hold_i      (cfg_hold),
    .ext_ready_i (ext_ready),
    .idle_o      (fsm_idle),
    .cs_o        (fsm_cs),
    .strobe_o    (fsm_strobe),
    .capture_o   (fsm_capture),
    .finish_o    (fsm_finish)
  );

  assign req_ready = fsm_idle;
  assign accept    = req_valid && req_ready;
  assign start     = accept && area_hit;
  assign miss      = accept && !area_hit;

  // Request capture
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      be_q    <= '0;
      write_q <= 1'b0;
    end else if (start) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
      be_q    <= be_masked;
      write_q <= req_write;
    end
  end

  // Response path
  always_comb begin
    rdata_en = miss || (fsm_capture && !write_q);
    rdata_d  = miss ? '0 : bus_rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (rdata_en) begin
      rdata_q <= rdata_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
    end else begin
      done_q <= miss || fsm_finish;
    end
  end

  assign rsp_done     = done_q;
  assign rsp_rdata    = rdata_q;
  assign bus_cs_n     = !fsm_cs;
  assign bus_rd_n     = !(fsm_strobe && !write_q);
  assign bus_we_n     = ~({LANES{fsm_strobe && write_q}} & be_q);
  assign bus_addr     = addr_q;
  assign bus_wdata    = wdata_q;
  assign bus_wdata_oe = fsm_cs && write_q;

  // R2
  cs_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_cs_n) |-> $past(req_valid && req_ready));

  // R7
  rd_we_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd_n |-> (bus_we_n == {LANES{1'b1}}));

  // R8
  strobe_in_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_rd_n || (bus_we_n != {LANES{1'b1}})) |-> !bus_cs_n);

  // R7
  done_on_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_cs_n) |-> rsp_done);

  // R9
  no_accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |-> bus_cs_n);

endmodule

// File: tb/sram_cycle_ctrl_bench.sv
module sram_cycle_ctrl_bench;

  localparam int CLK_P = 10;

  logic        clk, rst_n;
  logic        req_valid, req_ready, req_write;
  logic [31:0] req_addr;
  logic [63:0] req_wdata;
  logic [7:0]  req_be;
  logic        rsp_done;
  logic [63:0] rsp_rdata;
  logic [1:0]  cfg_width;
  logic [2:0]  cfg_wait;
  logic        cfg_setup;
  logic [1:0]  cfg_hold;
  logic        bus_cs_n, bus_rd_n, bus_wdata_oe;
  logic [7:0]  bus_we_n;
  logic [31:0] bus_addr;
  logic [63:0] bus_wdata, bus_rdata;
  logic        ext_ready;

  sram_cycle_ctrl u_sram_cycle_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
    .cfg_width(cfg_width), .cfg_wait(cfg_wait), .cfg_setup(cfg_setup),
    .cfg_hold(cfg_hold),
    .bus_cs_n(bus_cs_n), .bus_rd_n(bus_rd_n), .bus_we_n(bus_we_n),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_wdata_oe(bus_wdata_oe),
    .bus_rdata(bus_rdata), .ext_ready(ext_ready)
  );

  assign bus_rdata = {bus_addr, ~bus_addr};

  typedef struct packed {
    bit        hit;
    bit        wr;
    bit        early;
    bit        chg;
    int        setup;
    int        strobe;
    int        hold;
    int        waits;
    int        extra;
    bit [7:0]  wemask;
    bit [63:0] rdata;
    bit [63:0] wdata;
  } exp_t;

  exp_t exp_q[$];
  int   n_chk, n_err;
  int   wmap [8] = '{0, 1, 2, 3, 4, 6, 8, 15};

  initial begin
    clk = 1'b0;
    forever #(CLK_P / 2) clk = ~clk;
  end

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  // Monitor / bus model
  bit        m_cs, m_rd, m_busy_rdy;
  int        m_setup, m_str, m_hold;
  logic [7:0]  m_we;
  logic [63:0] m_wd;

  always @(negedge clk) begin
    if (rst_n) begin
      if (rsp_done) begin
        if (exp_q.size() == 0) begin
          check("R9 done with no pending request", 64'd1, 64'd0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          check(e.chg ? "R10 cs seen" : "R2 cs seen", 64'(m_cs), 64'(e.hit));
          check(e.chg ? "R10 setup cycles" : "R3 setup cycles", 64'(m_setup), 64'(e.setup));
          if (e.chg)
            check("R10 strobe cycles", 64'(m_str), 64'(e.strobe));
          else if (e.extra != 0 || e.early)
            check("R5 strobe cycles", 64'(m_str), 64'(e.strobe));
          else
            check("R4 strobe cycles", 64'(m_str), 64'(e.strobe));
          check(e.chg ? "R10 hold cycles" : "R6 hold cycles", 64'(m_hold), 64'(e.hold));
          check("R7 read strobe seen", 64'(m_rd), 64'(e.hit && !e.wr));
          check(e.chg ? "R10 write lanes" : "R8 write lanes", 64'(m_we), 64'(e.wemask));
          if (!e.wr) check(e.hit ? "R7 read data" : "R2 miss read data", rsp_rdata, e.rdata);
          if (e.wr && e.hit) check("R8 write data", m_wd, e.wdata);
          check("R9 ready low while busy", 64'(m_busy_rdy), 64'd0);
        end
        m_cs = 0; m_rd = 0; m_busy_rdy = 0;
        m_setup = 0; m_str = 0; m_hold = 0; m_we = '0; m_wd = '0;
      end
      ext_ready = 1'b1;
      if (!bus_cs_n) begin
        if (req_ready) m_busy_rdy = 1;
        m_cs = 1;
        if (!bus_rd_n || (bus_we_n != 8'hFF)) begin
          if (exp_q.size() != 0) begin
            int j, n, k;
            j = m_str; n = exp_q[0].waits; k = exp_q[0].extra;
            if (exp_q[0].early) ext_ready = (j >= n);
            else                ext_ready = !((j >= n) && (j < n + k));
          end
          m_str++;
          if (!bus_rd_n) m_rd = 1;
          m_we = m_we | ~bus_we_n;
          m_wd = bus_wdata;
        end else if (m_str == 0) begin
          m_setup++;
        end else begin
          m_hold++;
        end
      end
    end
  end

  // Driver
  task automatic do_req(input bit wr, input logic [31:0] addr, input logic [7:0] be,
                        input logic [63:0] wd, input logic [1:0] w, input logic [2:0] wc,
                        input bit s, input logic [1:0] h, input int k, input bit early,
                        input bit chg);
    exp_t e;
    bit   hit;
    logic [7:0] lanes;
    hit   = (addr[28:26] == 3'b010);
    lanes = 8'((16'd1 << (16'd1 << w)) - 16'd1);
    e.hit    = hit;
    e.wr     = wr;
    e.early  = early;
    e.chg    = chg;
    e.waits  = wmap[wc];
    e.extra  = early ? 0 : k;
    e.setup  = hit ? int'(s) : 0;
    e.strobe = hit ? (wmap[wc] + 1 + e.extra) : 0;
    e.hold   = hit ? int'(h) : 0;
    e.wemask = (hit && wr) ? (be & lanes) : 8'h00;
    e.rdata  = hit ? {addr, ~addr} : 64'd0;
    e.wdata  = wd;
    exp_q.push_back(e);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = addr; req_be = be; req_wdata = wd;
    cfg_width = w; cfg_wait = wc; cfg_setup = s; cfg_hold = h;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    if (chg) begin
      cfg_width = 2'd0; cfg_wait = 3'd0; cfg_setup = 1'b0; cfg_hold = 2'd0;
    end
  endtask

  initial begin
    n_chk = 0; n_err = 0;
    m_cs = 0; m_rd = 0; m_busy_rdy = 0; m_setup = 0; m_str = 0; m_hold = 0;
    m_we = '0; m_wd = '0;
    ext_ready = 1'b1;
    req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_be = '0; req_wdata = '0;
    cfg_width = 2'd3; cfg_wait = 3'd0; cfg_setup = 1'b0; cfg_hold = 2'd0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 cs_n", 64'(bus_cs_n), 64'd1);
    check("R1 rd_n", 64'(bus_rd_n), 64'd1);
    check("R1 we_n", 64'(bus_we_n), 64'hFF);
    check("R1 req_ready", 64'(req_ready), 64'd1);
    check("R1 rsp_done", 64'(rsp_done), 64'd0);

    //      wr addr          be     wdata                  w  wc s h  k early chg
    do_req(0, 32'h0800_0010, 8'hFF, 64'd0,                 3, 0, 0, 0, 0, 0, 0);
    do_req(0, 32'h0800_1234, 8'hFF, 64'd0,                 3, 2, 1, 1, 0, 0, 0);
    do_req(1, 32'h0800_0040, 8'hA5, 64'h1122334455667788, 3, 3, 0, 2, 0, 0, 0);
    do_req(1, 32'h0800_0080, 8'hFF, 64'hCAFEF00DDEADBEEF, 0, 1, 1, 0, 0, 0, 0);
    do_req(1, 32'h0800_00C0, 8'hFF, 64'h0102030405060708, 1, 0, 0, 1, 0, 0, 0);
    do_req(1, 32'h0800_0100, 8'h3C, 64'hA0A1A2A3A4A5A6A7, 2, 0, 1, 0, 0, 0, 0);
    do_req(0, 32'h0800_0200, 8'hFF, 64'd0,                 3, 7, 1, 3, 0, 0, 0);
    do_req(0, 32'h0800_0300, 8'hFF, 64'd0,                 3, 4, 0, 1, 3, 0, 0);
    do_req(0, 32'h0800_0400, 8'hFF, 64'd0,                 3, 5, 0, 0, 0, 1, 0);
    do_req(0, 32'h0C00_0500, 8'hFF, 64'd0,                 3, 2, 1, 2, 0, 0, 0);
    do_req(1, 32'h1000_0600, 8'hFF, 64'h5555AAAA5555AAAA, 3, 0, 0, 0, 0, 0, 0);
    do_req(1, 32'h0800_0700, 8'hFF, 64'h0F0F0F0FF0F0F0F0, 3, 6, 1, 2, 0, 0, 1);
    do_req(0, 32'h0C00_0800, 8'hFF, 64'd0,                 3, 0, 0, 0, 0, 0, 0);
    do_req(1, 32'h0800_0900, 8'h81, 64'h89ABCDEF01234567, 3, 7, 0, 0, 2, 0, 0);
    do_req(0, 32'h0800_0A00, 8'hFF, 64'd0,                 3, 1, 1, 3, 1, 0, 0);

    while (exp_q.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired actual=%0d pending expected=0", exp_q.size());
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule